// File: doc/BRIEF.md
# Buck Converter Start-up Sequencer and Fault Supervisor

This block is the digital control state machine of a synchronous buck regulator. Once enabled, it waits out a programmable power-on delay and then runs a programmable soft-start. After that it regulates normally. In regulation it watches a set of comparator flags from the analog front end and reacts to them. These flags report an output inside the narrow power-good window, an output outside the wide window, undervoltage, overvoltage and the negative inductor current limit. It produces gate-enable requests for the high-side and low-side switches. It also produces a debounced power-good output, the light-load mode selection (discontinuous or forced continuous) and latched fault flags.

All delays count a one-microsecond tick input. The delay codes, the undervoltage response (hiccup or latch) and the continuous-mode request are plain register inputs. On an undervoltage fault the block either restarts itself or stays off. On an overvoltage fault it runs a low-side pull-down loop and finally holds the low side on. Only a drop of the enable input, or a reset, clears a latched state.

Top module: `buck_seq_supervisor`

## Requirements
- R1: After reset with enable low, both gate requests, power-good, the soft-start indicator, the continuous-mode indicator and both fault flags are 0.
- R2: After enable rises, both gate requests stay 0 for a power-on delay of (256·2^code + 100) µs, with a 3-bit code (code 0 gives 356 µs, code 1 gives 612 µs). Every delay advances only on cycles where the tick input is 1.
- R3: Soft-start then lasts 1000·2^code µs for a 2-bit code. During soft-start the soft-start indicator is 1, and both gate requests are 1 during soft-start and normal regulation.
- R4: Power-good stays 0 during soft-start even with the output inside the window. Power-good is monitored only after soft-start ends.
- R5: Power-good rises once the narrow-window flag has stayed 1 for the power-good delay: 256·2^code µs for codes 0 to 6, and 131072 µs for code 7.
- R6: Power-good falls once the wide-window-violation flag has stayed 1 for 2 µs. A shorter violation, or an output between the two windows, leaves it high.
- R7: The undervoltage flag is ignored during soft-start. After soft-start it must persist for 1000 µs. Then both gate requests go to 0 and the undervoltage fault flag sets, and a shorter undervoltage has no effect.
- R8: The continuous-mode indicator is 0 during soft-start. In normal regulation it follows the continuous-mode request input.
- R9: With the hiccup bit at 1, soft-start restarts (8960 + 7·soft-start) µs after an undervoltage fault. With it at 0, the block stays off with both gate requests 0.
- R10: Enable low returns the block to off within one clock, clears both fault flags and resets every delay counter. The next enable rise runs the full power-on delay again.
- R11: An overvoltage flag in soft-start or regulation sets the overvoltage fault flag and gives high side 0, low side 1. Each negative-current-limit flag then gives high side 1, low side 0 for MIN_ON_CYC clock cycles, after which the low-side phase returns.
- R12: Undervoltage persisting 1000 µs during the overvoltage loop latches high side 0, low side 1. Further negative-current-limit flags are then ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (supply reset) |
| tick_us | input | 1 | One-microsecond timing strobe |
| en | input | 1 | Converter enable |
| pon_code | input | 3 | Power-on delay code |
| ss_code | input | 2 | Soft-start duration code |
| pgd_code | input | 3 | Power-good rise delay code |
| uv_hiccup | input | 1 | 1: hiccup restart after undervoltage, 0: latch off |
| fccm_req | input | 1 | Request forced continuous mode after soft-start |
| cmp_pg_in | input | 1 | Output inside the narrow (±8%) window |
| cmp_pg_out | input | 1 | Output outside the wide (±16%) window |
| cmp_uv | input | 1 | Feedback below 68% of target |
| cmp_ov | input | 1 | Feedback above 120% of target |
| cmp_neg_ilim | input | 1 | Negative inductor current limit reached |
| hs_en | output | 1 | High-side gate enable request |
| ls_en | output | 1 | Low-side gate enable request |
| pgood | output | 1 | Power-good |
| ss_active | output | 1 | Soft-start in progress |
| fccm_active | output | 1 | Forced continuous mode selected |
| uv_flag | output | 1 | Latched undervoltage fault |
| ov_flag | output | 1 | Latched overvoltage fault |

## Verification
The checker assumes that the comparator flags describe one physical output voltage. The narrow-window and wide-violation flags are never 1 together, and the power-good rise is reached only through a narrow-window flag that was already present in the cycle before. It also assumes that enable and all codes are synchronous levels. The directed scenarios respect this. They change a flag only at the falling clock edge, they clear the narrow-window flag before raising the wide-window violation, and they reach undervoltage and overvoltage from a stable in-window output.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_PON,
      ST_SS,
      ST_RUN,
      ST_OV_LS,
      ST_OV_HS,
      ST_HICCUP,
      ST_LATCH_UV,
      ST_LATCH_OV
   } bss_state_e;

endpackage

// File: rtl/bss_delay_lut.sv
// Maps the register codes to delay lengths in microsecond ticks.
module bss_delay_lut #(
   parameter int TW          = 18,
   parameter int PON_BASE_US = 256,
   parameter int PON_OFS_US  = 100,
   parameter int SS_BASE_US  = 1000,
   parameter int PGD_BASE_US = 256,
   parameter int PGD_TOP_US  = 131072,
   parameter int HIC_BASE_US = 8960,
   parameter int HIC_SS_MULT = 7
) (
   input  logic [2:0]    pon_code,
   input  logic [1:0]    ss_code,
   input  logic [2:0]    pgd_code,
   output logic [TW-1:0] pon_us,
   output logic [TW-1:0] ss_us,
   output logic [TW-1:0] pgd_us,
   output logic [TW-1:0] hic_us
);

   assign pon_us = TW'((PON_BASE_US << pon_code) + PON_OFS_US);
   assign ss_us  = TW'(SS_BASE_US << ss_code);
   assign hic_us = TW'(HIC_BASE_US + HIC_SS_MULT * (SS_BASE_US << ss_code));

   // The top power-good code either extends to a fixed long value or keeps doubling.
   generate
      if (PGD_TOP_US > 0) begin : g_pgd_top
         assign pgd_us = (pgd_code == 3'd7) ? TW'(PGD_TOP_US)
                                            : TW'(PGD_BASE_US << pgd_code);
      end else begin : g_pgd_shift
         assign pgd_us = TW'(PGD_BASE_US << pgd_code);
      end
   endgenerate

endmodule

// File: rtl/bss_persist.sv
// Counts ticks while a condition holds; reports once the threshold is reached.
module bss_persist #(
   parameter int TW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic          cond,
   input  logic [TW-1:0] thr,
   output logic          hit
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || !cond) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q < thr)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hit = cond && (cnt_q >= thr);

endmodule

// File: rtl/buck_seq_supervisor.sv
module buck_seq_supervisor
   import buck_seq_pkg::*;
#(
   parameter int TW          = 18,
   parameter int MIN_ON_CYC  = 4,
   parameter int PON_BASE_US = 256,
   parameter int PON_OFS_US  = 100,
   parameter int SS_BASE_US  = 1000,
   parameter int PGD_BASE_US = 256,
   parameter int PGD_TOP_US  = 131072,
   parameter int UV_DEB_US   = 1000,
   parameter int PG_FALL_US  = 2,
   parameter int HIC_BASE_US = 8960,
   parameter int HIC_SS_MULT = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_us,
   input  logic       en,
   input  logic [2:0] pon_code,
   input  logic [1:0] ss_code,
   input  logic [2:0] pgd_code,
   input  logic       uv_hiccup,
   input  logic       fccm_req,
   input  logic       cmp_pg_in,
   input  logic       cmp_pg_out,
   input  logic       cmp_uv,
   input  logic       cmp_ov,
   input  logic       cmp_neg_ilim,
   output logic       hs_en,
   output logic       ls_en,
   output logic       pgood,
   output logic       ss_active,
   output logic       fccm_active,
   output logic       uv_flag,
   output logic       ov_flag
);

   localparam int PON_MAX  = (PON_BASE_US << 7) + PON_OFS_US;
   localparam int PGD_SHFT = (PGD_TOP_US > 0) ? (PGD_BASE_US << 6) : (PGD_BASE_US << 7);
   localparam int PGD_MAX  = (PGD_TOP_US > PGD_SHFT) ? PGD_TOP_US : PGD_SHFT;
   localparam int HIC_MAX  = HIC_BASE_US + HIC_SS_MULT * (SS_BASE_US << 3);
   localparam int M1       = (PON_MAX > PGD_MAX) ? PON_MAX : PGD_MAX;
   localparam int M2       = (HIC_MAX > UV_DEB_US) ? HIC_MAX : UV_DEB_US;
   localparam int T_MAX    = (M1 > M2) ? M1 : M2;
   localparam int NEED_W   = $clog2(T_MAX + 1);
   localparam int MW       = $clog2(MIN_ON_CYC + 1);

   generate
      if (TW < NEED_W) begin : g_bad_tw
         $error("TW too narrow for the longest delay");
      end
      if (MIN_ON_CYC < 1) begin : g_bad_min_on
         $error("MIN_ON_CYC must be at least 1");
      end
      if (PG_FALL_US < 1 || UV_DEB_US < 1) begin : g_bad_deb
         $error("debounce lengths must be positive");
      end
   endgenerate

   bss_state_e state_q, state_d;

   logic [TW-1:0] pon_us, ss_us, pgd_us, hic_us;
   logic [TW-1:0] ph_thr;
   logic          ph_hit, uv_hit, rise_hit, fall_hit;
   logic          ph_clr, uv_guard, in_run;
   logic [MW-1:0] min_q;
   logic          pgood_q, uv_q, ov_q;

   bss_delay_lut #(
      .TW          (TW),
      .PON_BASE_US (PON_BASE_US),
      .PON_OFS_US  (PON_OFS_US),
      .SS_BASE_US  (SS_BASE_US),
      .PGD_BASE_US (PGD_BASE_US),
      .PGD_TOP_US  (PGD_TOP_US),
      .HIC_BASE_US (HIC_BASE_US),
      .HIC_SS_MULT (HIC_SS_MULT)
   ) u_lut (
      .pon_code (pon_code),
      .ss_code  (ss_code),
      .pgd_code (pgd_code),
      .pon_us   (pon_us),
      .ss_us    (ss_us),
      .pgd_us   (pgd_us),
      .hic_us   (hic_us)
   );

   // Phase timer: restarts on every state change.
   always_comb begin
      unique case (state_q)
         ST_PON:    ph_thr = pon_us;
         ST_SS:     ph_thr = ss_us;
         ST_HICCUP: ph_thr = hic_us;
         default:   ph_thr = '0;
      endcase
   end

   assign ph_clr   = (state_d != state_q);
   assign in_run   = (state_q == ST_RUN);
   assign uv_guard = (state_q == ST_RUN) || (state_q == ST_OV_LS) || (state_q == ST_OV_HS);

   bss_persist #(.TW(TW)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ph_clr),
      .tick  (tick_us),
      .cond  (1'b1),
      .thr   (ph_thr),
      .hit   (ph_hit)
   );

   bss_persist #(.TW(TW)) u_uv_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en),
      .tick  (tick_us),
      .cond  (cmp_uv && uv_guard),
      .thr   (TW'(UV_DEB_US)),
      .hit   (uv_hit)
   );

   bss_persist #(.TW(TW)) u_pg_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en),
      .tick  (tick_us),
      .cond  (cmp_pg_in && in_run),
      .thr   (pgd_us),
      .hit   (rise_hit)
   );

   bss_persist #(.TW(TW)) u_pg_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en),
      .tick  (tick_us),
      .cond  (cmp_pg_out && in_run),
      .thr   (TW'(PG_FALL_US)),
      .hit   (fall_hit)
   );

   // Sequencing and fault reaction.
   always_comb begin
      state_d = state_q;
      if (!en) begin
         state_d = ST_OFF;
      end else begin
         unique case (state_q)
            ST_OFF:    state_d = ST_PON;
            ST_PON:    if (ph_hit) state_d = ST_SS;
            ST_SS: begin
               if (cmp_ov)      state_d = ST_OV_LS;
               else if (ph_hit) state_d = ST_RUN;
            end
            ST_RUN: begin
               if (cmp_ov)      state_d = ST_OV_LS;
               else if (uv_hit) state_d = uv_hiccup ? ST_HICCUP : ST_LATCH_UV;
            end
            ST_OV_LS: begin
               if (uv_hit)            state_d = ST_LATCH_OV;
               else if (cmp_neg_ilim) state_d = ST_OV_HS;
            end
            ST_OV_HS: begin
               if (uv_hit)                          state_d = ST_LATCH_OV;
               else if (min_q == MW'(MIN_ON_CYC-1)) state_d = ST_OV_LS;
            end
            ST_HICCUP: if (ph_hit) state_d = ST_SS;
            default:   state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         min_q   <= '0;
         pgood_q <= 1'b0;
         uv_q    <= 1'b0;
         ov_q    <= 1'b0;
      end else begin
         state_q <= state_d;

         if (state_q == ST_OV_HS && state_d == ST_OV_HS) min_q <= min_q + 1'b1;
         else                                            min_q <= '0;

         if (state_d != ST_RUN)  pgood_q <= 1'b0;
         else if (fall_hit)      pgood_q <= 1'b0;
         else if (rise_hit)      pgood_q <= 1'b1;

         if (!en)                                              uv_q <= 1'b0;
         else if (state_q == ST_RUN &&
                  (state_d == ST_HICCUP || state_d == ST_LATCH_UV)) uv_q <= 1'b1;

         if (!en)                                              ov_q <= 1'b0;
         else if ((state_q == ST_SS || state_q == ST_RUN) &&
                  state_d == ST_OV_LS)                         ov_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (state_q)
         ST_SS, ST_RUN:           begin hs_en = 1'b1; ls_en = 1'b1; end
         ST_OV_LS, ST_LATCH_OV:   begin hs_en = 1'b0; ls_en = 1'b1; end
         ST_OV_HS:                begin hs_en = 1'b1; ls_en = 1'b0; end
         default:                 begin hs_en = 1'b0; ls_en = 1'b0; end
      endcase
   end

   assign ss_active   = (state_q == ST_SS);
   assign fccm_active = fccm_req && in_run;
   assign pgood       = pgood_q;
   assign uv_flag     = uv_q;
   assign ov_flag     = ov_q;

endmodule

// File: rtl/bss_checker.sv
module bss_checker (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic cmp_pg_in,
   input logic hs_en,
   input logic ls_en,
   input logic pgood,
   input logic ss_active,
   input logic fccm_active,
   input logic uv_flag,
   input logic ov_flag
);

   p_pgood_only_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pgood |-> (hs_en && ls_en && !ss_active));

   p_rise_needs_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood) |-> $past(cmp_pg_in));

   p_no_fccm_in_ss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ss_active |-> !fccm_active);

   p_enable_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!hs_en && !ls_en && !uv_flag && !ov_flag && !pgood));

   p_uv_gates_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uv_flag) |-> (!hs_en && !ls_en));

   p_ov_low_side_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ov_flag) |-> (ls_en && !hs_en));

endmodule

bind buck_seq_supervisor bss_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .cmp_pg_in   (cmp_pg_in),
   .hs_en       (hs_en),
   .ls_en       (ls_en),
   .pgood       (pgood),
   .ss_active   (ss_active),
   .fccm_active (fccm_active),
   .uv_flag     (uv_flag),
   .ov_flag     (ov_flag)
);

// File: tb/buck_seq_supervisor_test.sv
`timescale 1ns/1ps
module buck_seq_supervisor_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_us = 1'b1;
   logic en = 1'b0;
   logic [2:0] pon_code = 3'd0;
   logic [1:0] ss_code = 2'd0;
   logic [2:0] pgd_code = 3'd0;
   logic uv_hiccup = 1'b0;
   logic fccm_req = 1'b0;
   logic cmp_pg_in = 1'b0, cmp_pg_out = 1'b0, cmp_uv = 1'b0, cmp_ov = 1'b0, cmp_neg_ilim = 1'b0;
   logic hs_en, ls_en, pgood, ss_active, fccm_active, uv_flag, ov_flag;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   buck_seq_supervisor uut (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .en(en),
      .pon_code(pon_code), .ss_code(ss_code), .pgd_code(pgd_code),
      .uv_hiccup(uv_hiccup), .fccm_req(fccm_req),
      .cmp_pg_in(cmp_pg_in), .cmp_pg_out(cmp_pg_out), .cmp_uv(cmp_uv),
      .cmp_ov(cmp_ov), .cmp_neg_ilim(cmp_neg_ilim),
      .hs_en(hs_en), .ls_en(ls_en), .pgood(pgood), .ss_active(ss_active),
      .fccm_active(fccm_active), .uv_flag(uv_flag), .ov_flag(ov_flag)
   );

   function automatic int pon_len(int c); return (256 << c) + 100; endfunction
   function automatic int ss_len(int c);  return 1000 << c; endfunction
   function automatic int pgd_len(int c); return (c == 7) ? 131072 : (256 << c); endfunction

   function automatic bit pick(int sel);
      case (sel)
         0: return ss_active;
         1: return pgood;
         2: return hs_en;
         3: return ls_en;
         4: return uv_flag;
         default: return ov_flag;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_win(input string tag, input int act, input int exp);
      chk((act >= exp - 2) && (act <= exp + 2), tag, act, exp);
   endtask

   task automatic cyc(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic wait_for(input int sel, input bit lvl, input int maxc, output int n);
      n = 0;
      while (pick(sel) !== lvl && n < maxc) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; en = 1'b0; tick_us = 1'b1;
      pon_code = 3'd0; ss_code = 2'd0; pgd_code = 3'd0;
      uv_hiccup = 1'b0; fccm_req = 1'b0;
      cmp_pg_in = 1'b0; cmp_pg_out = 1'b0; cmp_uv = 1'b0; cmp_ov = 1'b0; cmp_neg_ilim = 1'b0;
      cyc(4);
      rst_n = 1'b1;
      cyc(2);
   endtask

   task automatic bring_up();
      int n;
      en = 1'b1;
      wait_for(0, 1'b1, 40000, n);
      wait_for(0, 1'b0, 40000, n);
   endtask

   task automatic t_reset();
      do_reset();
      chk(!hs_en && !ls_en, "R1 gates after reset", hs_en + ls_en, 0);
      chk(!pgood && !ss_active && !fccm_active, "R1 status after reset", pgood + ss_active + fccm_active, 0);
      chk(!uv_flag && !ov_flag, "R1 flags after reset", uv_flag + ov_flag, 0);
   endtask

   task automatic t_startup();
      int n;
      do_reset();
      fccm_req = 1'b1; cmp_pg_in = 1'b1;
      en = 1'b1;
      cyc(5);
      chk(!hs_en && !ls_en, "R2 gates off in power-on delay", hs_en + ls_en, 0);
      wait_for(0, 1'b1, 5000, n);
      chk_win("R2 power-on delay code0", n + 5, pon_len(0) + 1);
      chk(hs_en && ls_en, "R3 gates on in soft-start", hs_en + ls_en, 2);
      chk(!fccm_active, "R8 no fccm in soft-start", fccm_active, 0);
      chk(!pgood, "R4 pgood low at soft-start begin", pgood, 0);
      cyc(500);
      chk(!pgood, "R4 pgood low mid soft-start", pgood, 0);
      wait_for(0, 1'b0, 5000, n);
      chk_win("R3 soft-start code0", n + 500, ss_len(0) + 1);
      chk(fccm_active, "R8 fccm after soft-start", fccm_active, 1);
      wait_for(1, 1'b1, 5000, n);
      chk_win("R5 pgood delay code0", n, pgd_len(0) + 1);
      fccm_req = 1'b0;
      cyc(1);
      chk(!fccm_active, "R8 fccm follows request", fccm_active, 0);
   endtask

   task automatic t_codes();
      int n;
      do_reset();
      pon_code = 3'd1; ss_code = 2'd1; pgd_code = 3'd1;
      en = 1'b1;
      wait_for(0, 1'b1, 5000, n);
      chk_win("R2 power-on delay code1", n, pon_len(1) + 1);
      wait_for(0, 1'b0, 5000, n);
      chk_win("R3 soft-start code1", n, ss_len(1) + 1);
      cmp_pg_in = 1'b1;
      wait_for(1, 1'b1, 5000, n);
      chk_win("R5 pgood delay code1", n, pgd_len(1) + 1);
   endtask

   task automatic t_tick_gate();
      int n;
      do_reset();
      tick_us = 1'b0;
      en = 1'b1;
      cyc(2000);
      chk(!ss_active && !hs_en, "R2 no progress without tick", ss_active + hs_en, 0);
      tick_us = 1'b1;
      wait_for(0, 1'b1, 5000, n);
      chk_win("R2 delay counted from tick", n, pon_len(0) + 1);
   endtask

   task automatic t_pgood();
      int n;
      do_reset();
      bring_up();
      cmp_pg_in = 1'b1;
      wait_for(1, 1'b1, 5000, n);
      chk(pgood, "R5 pgood up", pgood, 1);
      cmp_pg_in = 1'b0;
      cyc(100);
      chk(pgood, "R6 between windows holds", pgood, 1);
      cmp_pg_out = 1'b1;
      cyc(1);
      cmp_pg_out = 1'b0;
      cyc(10);
      chk(pgood, "R6 short violation ignored", pgood, 1);
      cmp_pg_out = 1'b1;
      cyc(1);
      chk(pgood, "R6 still high after 1 us", pgood, 1);
      cyc(3);
      chk(!pgood, "R6 falls after 2 us", pgood, 0);
      cmp_pg_out = 1'b0; cmp_pg_in = 1'b1;
      wait_for(1, 1'b1, 5000, n);
      chk_win("R5 pgood returns after delay", n, pgd_len(0) + 1);
   endtask

   task automatic t_uv_latch();
      int n;
      do_reset();
      ss_code = 2'd1; uv_hiccup = 1'b0; cmp_uv = 1'b1;
      bring_up();
      chk(!uv_flag && hs_en, "R7 undervoltage ignored in soft-start", uv_flag, 0);
      cyc(500);
      cmp_uv = 1'b0;
      cyc(1500);
      chk(!uv_flag && hs_en && ls_en, "R7 short undervoltage ignored", uv_flag, 0);
      cmp_uv = 1'b1;
      wait_for(4, 1'b1, 5000, n);
      chk_win("R7 undervoltage debounce", n, 1001);
      chk(!hs_en && !ls_en, "R7 gates off on undervoltage", hs_en + ls_en, 0);
      cmp_uv = 1'b0;
      cyc(20000);
      chk(!ss_active && !hs_en && !ls_en && uv_flag, "R9 latch mode stays off", ss_active + hs_en, 0);
      en = 1'b0;
      cyc(2);
      chk(!uv_flag, "R10 enable low clears fault", uv_flag, 0);
      en = 1'b1;
      wait_for(0, 1'b1, 5000, n);
      chk_win("R10 restart after enable toggle", n, pon_len(0) + 1);
   endtask

   task automatic t_hiccup();
      int n;
      do_reset();
      uv_hiccup = 1'b1;
      bring_up();
      cmp_uv = 1'b1;
      wait_for(4, 1'b1, 5000, n);
      cmp_uv = 1'b0;
      wait_for(0, 1'b1, 30000, n);
      chk_win("R9 hiccup restart delay", n, 8960 + 7 * ss_len(0) + 1);
      wait_for(0, 1'b0, 5000, n);
      chk(hs_en && ls_en, "R9 regulation after hiccup", hs_en + ls_en, 2);
   endtask

   task automatic t_ov();
      int hs_cnt;
      do_reset();
      bring_up();
      cmp_pg_in = 1'b1;
      cyc(300);
      cmp_ov = 1'b1;
      cyc(1);
      cmp_ov = 1'b0;
      chk(!hs_en && ls_en && ov_flag, "R11 low side on at overvoltage", hs_en, 0);
      chk(!pgood, "R11 pgood drops on overvoltage", pgood, 0);
      cyc(20);
      chk(!hs_en && ls_en, "R11 low side held until limit", ls_en, 1);
      hs_cnt = 0;
      cmp_neg_ilim = 1'b1;
      for (int i = 0; i < 8; i++) begin
         cyc(1);
         if (i == 0) cmp_neg_ilim = 1'b0;
         if (hs_en && !ls_en) hs_cnt++;
      end
      chk(hs_cnt == 4, "R11 minimum on-time cycles", hs_cnt, 4);
      chk(!hs_en && ls_en, "R11 back to low side", ls_en, 1);
      cmp_pg_in = 1'b0; cmp_uv = 1'b1;
      cyc(1010);
      chk(!hs_en && ls_en && ov_flag, "R12 latched low side on", ls_en, 1);
      hs_cnt = 0;
      cmp_neg_ilim = 1'b1;
      for (int i = 0; i < 6; i++) begin
         cyc(1);
         if (hs_en) hs_cnt++;
      end
      cmp_neg_ilim = 1'b0;
      chk(hs_cnt == 0, "R12 limit ignored when latched", hs_cnt, 0);
      cmp_uv = 1'b0;
      en = 1'b0;
      cyc(2);
      chk(!ov_flag && !ls_en, "R10 enable low clears overvoltage latch", ov_flag + ls_en, 0);
   endtask

   task automatic t_en_restart();
      int n;
      do_reset();
      en = 1'b1;
      cyc(300);
      en = 1'b0;
      cyc(1);
      en = 1'b1;
      wait_for(0, 1'b1, 5000, n);
      chk_win("R10 counters reset by enable drop", n, pon_len(0) + 1);
   endtask

   initial begin
      t_reset();
      t_startup();
      t_codes();
      t_tick_gate();
      t_pgood();
      t_uv_latch();
      t_hiccup();
      t_ov();
      t_en_restart();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule